// File: doc/BRIEF.md
# Character Translation Dispatcher

This block takes a stream of 8-bit characters and, for each one, looks up a 12-bit word in a 256-entry translation memory. The top four bits of the word are flags. Together with a sticky delimiter-hold bit left by the previous character, they select one of four actions:

- pass the raw character through;
- emit the translated code from the low byte of the word;
- request a vertical-format (paper motion) action;
- stop with an undefined-character interrupt.

The chosen action and its payload leave through a registered output stage with a valid/ready handshake. The downstream print and paper-motion engines consume it there.

A host loads the translation memory in two steps. It first places the target address in a character buffer register, then writes the 12-bit word. A write is only taken in a cycle where no character is being dispatched and no action is waiting at the output.

After a stop action, the dispatcher refuses further characters until the host pulses a resume input.

Top module: `char_xlat_dispatch`

## Requirements
- R1: After reset, no action is presented (`act_valid` = 0). Delimiter-hold and the undefined-character status are 0, and `chr_ready` is 1.
- R2: An accepted host write stores the 12-bit `mem_data` at the address held in the character buffer register. The buffer register is loaded from `buf_data` when `buf_load` is high. A later lookup of that character uses the stored word.
- R3: Word bits 11, 10, 9 and 8 are the interrupt, delimiter, translate and paper-motion flags. With interrupt and paper-motion clear, the action is translate (`act_kind` = 1, `act_code` = word bits 7:0) if translate, delimiter or hold is set. Otherwise it is raw (`act_kind` = 0, `act_code` = the character).
- R4: With interrupt clear and paper-motion set, the action is format (`act_kind` = 2) if translate, delimiter or hold is set. Otherwise it is raw.
- R5: With the interrupt flag set, the action is stop (`act_kind` = 3, `act_code` = the character) if translate is clear or delimiter or hold is set. Otherwise it is format if paper-motion is set, and translate if it is not.
- R6: Each accepted character loads delimiter-hold from bit 10 of its word, after its own action has been chosen with the old hold value. Hold changes at no other time.
- R7: Every accepted character clears the undefined-character status. A stop action sets it instead and halts intake (`chr_ready` = 0). A `resume` pulse clears both.
- R8: For a format action, `act_slew` carries word bit 4 (1 = slew by a line count, 0 = skip to a channel) and `act_count` carries word bits 3:0.
- R9: `wr_accept` is 1 only when `mem_wr` is high, no character is accepted in that cycle, and no action is pending. A rejected write leaves the memory unchanged.
- R10: While `act_valid` is 1 and `act_ready` is 0, the presented action stays stable and `chr_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chr_valid | input | 1 | Character offered |
| chr_data | input | 8 | Character code |
| chr_ready | output | 1 | Character taken this cycle when valid |
| buf_load | input | 1 | Load character buffer register |
| buf_data | input | 8 | Address for host memory writes |
| mem_wr | input | 1 | Host write request to translation memory |
| mem_data | input | 12 | Word to store |
| wr_accept | output | 1 | Host write taken this cycle |
| resume | input | 1 | Clear halt and undefined status |
| act_valid | output | 1 | Action presented |
| act_ready | input | 1 | Consumer takes action |
| act_kind | output | 2 | 0 raw, 1 translate, 2 format, 3 stop |
| act_code | output | 8 | Character or translated code |
| act_slew | output | 1 | Format mode: 1 slew, 0 channel skip |
| act_count | output | 4 | Line count or channel number |
| delim_hold | output | 1 | Current delimiter-hold flag |
| undef_chr | output | 1 | Undefined-character status |

## Verification
The host write port and character dispatch share the translation memory. Both can be requested in one cycle. The bench provokes the clash by raising `mem_wr` in the same cycle that a character is handshaken. It then checks that `wr_accept` stays low, that the character receives the action of the old word, and that a later lookup of the targeted address still returns the old word. A second clash arises between the stop action and the next character. The bench checks that intake stays closed until resume, and that delimiter-hold carries from one character into the next character's decision.

// File: rtl/cxd_pkg.sv
package cxd_pkg;

  typedef enum logic [1:0] {
    ACT_RAW  = 2'd0,
    ACT_XLAT = 2'd1,
    ACT_FMT  = 2'd2,
    ACT_STOP = 2'd3
  } act_e;

  // Decision rules; index is {intr, delim, xlat, paper, hold}
  function automatic act_e rule_action(input logic [4:0] idx);
    logic f_int, f_dlm, f_xl, f_pp, f_hd;
    act_e r;
    {f_int, f_dlm, f_xl, f_pp, f_hd} = idx;
    if (f_int) begin
      if (!f_xl || f_dlm || f_hd) r = ACT_STOP;
      else if (f_pp)              r = ACT_FMT;
      else                        r = ACT_XLAT;
    end else if (f_pp) begin
      if (f_xl || f_dlm || f_hd)  r = ACT_FMT;
      else                        r = ACT_RAW;
    end else begin
      if (f_xl || f_dlm || f_hd)  r = ACT_XLAT;
      else                        r = ACT_RAW;
    end
    return r;
  endfunction

endpackage

// File: rtl/cxd_xlat_ram.sv
module cxd_xlat_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/cxd_case_rom.sv
module cxd_case_rom
  import cxd_pkg::*;
#(
  parameter int FLAG_N = 4
) (
  input  logic [FLAG_N:0] idx,
  output act_e            act
);
  localparam int IDX_W   = FLAG_N + 1;
  localparam int ENTRIES = 1 << IDX_W;

  act_e tbl [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    assign tbl[i] = rule_action(5'(i));
  end

  assign act = tbl[idx];
endmodule

// File: rtl/cxd_status.sv
module cxd_status (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic delim_bit,
  input  logic stop_evt,
  input  logic resume,
  output logic hold,
  output logic undef,
  output logic halted
);
  logic hold_n, undef_n, halted_n;

  always_comb begin
    hold_n   = hold;
    undef_n  = undef;
    halted_n = halted;
    if (accept) begin
      hold_n  = delim_bit;
      undef_n = stop_evt;
    end else if (resume) begin
      undef_n = 1'b0;
    end
    if (accept && stop_evt) halted_n = 1'b1;
    else if (resume)        halted_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold   <= 1'b0;
      undef  <= 1'b0;
      halted <= 1'b0;
    end else begin
      hold   <= hold_n;
      undef  <= undef_n;
      halted <= halted_n;
    end
  end

  p_hold_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(hold));

  p_undef_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(undef) |-> $past(stop_evt && accept));

  p_resume_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (resume && !accept) |=> !halted && !undef);
endmodule

// File: rtl/char_xlat_dispatch.sv
module char_xlat_dispatch
  import cxd_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chr_valid,
  input  logic [CHAR_W-1:0] chr_data,
  output logic              chr_ready,
  input  logic              buf_load,
  input  logic [CHAR_W-1:0] buf_data,
  input  logic              mem_wr,
  input  logic [WORD_W-1:0] mem_data,
  output logic              wr_accept,
  input  logic              resume,
  output logic              act_valid,
  input  logic              act_ready,
  output logic [1:0]        act_kind,
  output logic [CHAR_W-1:0] act_code,
  output logic              act_slew,
  output logic [3:0]        act_count,
  output logic              delim_hold,
  output logic              undef_chr
);
  localparam int FLAG_N  = 4;
  localparam int FLAG_HI = WORD_W - 1;
  localparam int DLM_BIT = WORD_W - 2;
  localparam int SLEW_BIT = 4;

  logic [CHAR_W-1:0] cbuf, cbuf_n;
  logic [WORD_W-1:0] word;
  logic              accept, halted;
  act_e              act_sel;
  logic              av_n, sl_n;
  logic [1:0]        ak_n;
  logic [CHAR_W-1:0] ac_n;
  logic [3:0]        cnt_n;

  assign chr_ready = !halted && (!act_valid || act_ready);
  assign accept    = chr_valid && chr_ready;
  assign wr_accept = mem_wr && !accept && !act_valid;

  // character buffer register (host address)
  always_comb begin
    cbuf_n = cbuf;
    if (buf_load) cbuf_n = buf_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cbuf <= '0;
    else        cbuf <= cbuf_n;
  end

  cxd_xlat_ram #(.ADDR_W(CHAR_W), .DATA_W(WORD_W)) u_ram (
    .clk   (clk),
    .we    (wr_accept),
    .waddr (cbuf),
    .wdata (mem_data),
    .raddr (chr_data),
    .rdata (word)
  );

  cxd_case_rom #(.FLAG_N(FLAG_N)) u_rom (
    .idx ({word[FLAG_HI -: FLAG_N], delim_hold}),
    .act (act_sel)
  );

  cxd_status u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .delim_bit (word[DLM_BIT]),
    .stop_evt  (act_sel == ACT_STOP),
    .resume    (resume),
    .hold      (delim_hold),
    .undef     (undef_chr),
    .halted    (halted)
  );

  // action output stage
  always_comb begin
    av_n  = act_valid;
    ak_n  = act_kind;
    ac_n  = act_code;
    sl_n  = act_slew;
    cnt_n = act_count;
    if (accept) begin
      av_n  = 1'b1;
      ak_n  = act_sel;
      ac_n  = (act_sel == ACT_RAW || act_sel == ACT_STOP) ? chr_data
                                                         : word[CHAR_W-1:0];
      sl_n  = word[SLEW_BIT];
      cnt_n = word[3:0];
    end else if (act_ready) begin
      av_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_valid <= 1'b0;
      act_kind  <= 2'd0;
      act_code  <= '0;
      act_slew  <= 1'b0;
      act_count <= '0;
    end else begin
      act_valid <= av_n;
      act_kind  <= ak_n;
      act_code  <= ac_n;
      act_slew  <= sl_n;
      act_count <= cnt_n;
    end
  end

  p_stall_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && !act_ready) |=> act_valid && $stable(act_kind) && $stable(act_code));

  p_stall_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && !act_ready) |-> !chr_ready);

  p_write_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |-> !(chr_valid && chr_ready) && !act_valid);

  p_stop_halts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && act_sel == ACT_STOP) |=> !chr_ready && undef_chr);

  p_halt_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !chr_ready);
endmodule

// File: tb/tb_char_xlat_dispatch.sv
module tb_char_xlat_dispatch;
  logic clk = 1'b0;
  logic rst_n;
  logic chr_valid, buf_load, mem_wr, resume, act_ready;
  logic [7:0] chr_data, buf_data;
  logic [11:0] mem_data;
  logic chr_ready, wr_accept, act_valid, act_slew, delim_hold, undef_chr;
  logic [1:0] act_kind;
  logic [7:0] act_code;
  logic [3:0] act_count;

  always #5 clk = ~clk;

  char_xlat_dispatch dut (
    .clk(clk), .rst_n(rst_n), .chr_valid(chr_valid), .chr_data(chr_data),
    .chr_ready(chr_ready), .buf_load(buf_load), .buf_data(buf_data),
    .mem_wr(mem_wr), .mem_data(mem_data), .wr_accept(wr_accept),
    .resume(resume), .act_valid(act_valid), .act_ready(act_ready),
    .act_kind(act_kind), .act_code(act_code), .act_slew(act_slew),
    .act_count(act_count), .delim_hold(delim_hold), .undef_chr(undef_chr)
  );

  typedef struct packed {
    logic [1:0] kind;
    logic [7:0] code;
    logic       slew;
    logic [3:0] cnt;
    logic [7:0] ch;
  } exp_t;

  exp_t exp_q[$];
  logic [11:0] model [256];
  logic m_hold;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] mk(input bit i, input bit d, input bit x,
                                     input bit p, input logic [7:0] lo);
    return {i, d, x, p, lo};
  endfunction

  // expected action from the stated rules
  function automatic exp_t predict(input logic [7:0] ch, input logic [11:0] w, input bit h);
    exp_t e;
    bit fi, fd, fx, fp;
    {fi, fd, fx, fp} = w[11:8];
    if (fi) begin
      if (!fx || fd || h) e.kind = 2'd3;
      else if (fp)        e.kind = 2'd2;
      else                e.kind = 2'd1;
    end else if (fp) e.kind = (fx || fd || h) ? 2'd2 : 2'd0;
    else             e.kind = (fx || fd || h) ? 2'd1 : 2'd0;
    e.code = (e.kind == 2'd0 || e.kind == 2'd3) ? ch : w[7:0];
    e.slew = w[4];
    e.cnt  = w[3:0];
    e.ch   = ch;
    return e;
  endfunction

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_n && act_valid && act_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R3 unexpected action", act_kind, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          check(act_kind == e.kind, "R3/R4/R5 kind", act_kind, e.kind);
          check(act_code == e.code, "R2/R3 code", act_code, e.code);
          if (e.kind == 2'd2) begin
            check(act_slew == e.slew, "R8 slew", act_slew, e.slew);
            check(act_count == e.cnt, "R8 count", act_count, e.cnt);
          end
        end
      end
    end
  end

  task automatic hwrite(input logic [7:0] a, input logic [11:0] w);
    @(negedge clk); buf_load = 1'b1; buf_data = a;
    @(negedge clk); buf_load = 1'b0; mem_wr = 1'b1; mem_data = w;
    #2;
    if (wr_accept) model[a] = w;
    check(wr_accept == 1'b1, "R9 idle write accepted", wr_accept, 1);
    @(negedge clk); mem_wr = 1'b0;
  endtask

  task automatic send_char(input logic [7:0] ch);
    exp_t e;
    @(negedge clk); chr_valid = 1'b1; chr_data = ch;
    #2;
    while (!chr_ready) begin @(negedge clk); #2; end
    e = predict(ch, model[ch], m_hold);
    exp_q.push_back(e);
    m_hold = model[ch][10];
    @(posedge clk); #1; chr_valid = 1'b0;
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; chr_valid = 0; chr_data = 0; buf_load = 0; buf_data = 0;
    mem_wr = 0; mem_data = 0; resume = 0; act_ready = 1; m_hold = 0;
    repeat (3) @(negedge clk);
    #2;
    // R1 reset state
    check(act_valid == 0, "R1 act_valid", act_valid, 0);
    check(chr_ready == 1, "R1 chr_ready", chr_ready, 1);
    check(delim_hold == 0, "R1 delim_hold", delim_hold, 0);
    check(undef_chr == 0, "R1 undef_chr", undef_chr, 0);
    @(negedge clk); rst_n = 1'b1;

    // R2: load every entry, flags clear
    for (int a = 0; a < 256; a++) hwrite(8'(a), mk(0, 0, 0, 0, 8'(a) ^ 8'h5A));

    // R3: raw and translate
    send_char(8'h41);
    hwrite(8'h42, mk(0, 0, 1, 0, 8'hC3));
    send_char(8'h42);
    // R4: paper only -> raw, paper+xlat -> format (R8 slew and channel)
    hwrite(8'h10, mk(0, 0, 0, 1, 8'h15));
    send_char(8'h10);
    hwrite(8'h11, mk(0, 0, 1, 1, 8'h15));
    send_char(8'h11);
    hwrite(8'h12, mk(0, 0, 1, 1, 8'h0B));
    send_char(8'h12);
    // R5: interrupt with translate -> xlat, with paper -> format, with delim -> stop
    hwrite(8'h20, mk(1, 0, 1, 0, 8'h77));
    send_char(8'h20);
    hwrite(8'h21, mk(1, 0, 1, 1, 8'h13));
    send_char(8'h21);
    drain;
    // R6: delimiter sets hold, next plain char translated
    hwrite(8'h30, mk(0, 1, 0, 0, 8'h99));
    send_char(8'h30);
    drain;
    check(delim_hold == 1, "R6 hold after delim", delim_hold, 1);
    send_char(8'h41);
    drain;
    check(delim_hold == 0, "R6 hold cleared", delim_hold, 0);
    send_char(8'h41);
    send_char(8'h30);
    send_char(8'h10);
    send_char(8'h30);
    send_char(8'h20);
    drain;
    // R7: stop halts until resume
    check(undef_chr == 1, "R7 undef set on stop", undef_chr, 1);
    check(chr_ready == 0, "R7 halted after stop", chr_ready, 0);
    @(negedge clk); #2;
    check(chr_ready == 0, "R7 still halted", chr_ready, 0);
    @(negedge clk); resume = 1'b1;
    @(negedge clk); resume = 1'b0; #2;
    check(chr_ready == 1, "R7 resumed", chr_ready, 1);
    check(undef_chr == 0, "R7 undef cleared", undef_chr, 0);
    hwrite(8'h22, mk(1, 0, 0, 0, 8'h01));
    send_char(8'h22);
    drain;
    check(undef_chr == 1, "R7 stop without translate", undef_chr, 1);
    @(negedge clk); resume = 1'b1;
    @(negedge clk); resume = 1'b0;
    send_char(8'h41);
    drain;
    check(undef_chr == 0, "R7 cleared by lookup", undef_chr, 0);

    // R9: write clashing with a dispatch is rejected
    @(negedge clk); buf_load = 1'b1; buf_data = 8'h55;
    @(negedge clk); buf_load = 1'b0;
    chr_valid = 1'b1; chr_data = 8'h41; mem_wr = 1'b1; mem_data = mk(0, 0, 1, 0, 8'hEE);
    #2;
    check(chr_ready == 1, "R9 dispatch proceeds", chr_ready, 1);
    check(wr_accept == 0, "R9 clash write rejected", wr_accept, 0);
    exp_q.push_back(predict(8'h41, model[8'h41], m_hold));
    m_hold = model[8'h41][10];
    @(posedge clk); #1; chr_valid = 1'b0;
    #1; check(wr_accept == 0, "R9 pending action blocks write", wr_accept, 0);
    @(negedge clk); mem_wr = 1'b0;
    drain;
    send_char(8'h55);
    drain;

    // R10: backpressure
    @(negedge clk); act_ready = 1'b0;
    send_char(8'h42);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #2;
      check(act_valid == 1 && act_code == 8'hC3, "R10 held action", act_code, 8'hC3);
      check(chr_ready == 0, "R10 intake blocked", chr_ready, 0);
    end
    @(negedge clk); act_ready = 1'b1;
    drain;
    check(exp_q.size() == 0, "R3 all actions seen", exp_q.size(), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule